// File: doc/BRIEF.md
# Shift Unit with Flags

A combinational 32-bit shifter for a compact processor datapath. It can shift the operand left logically, right logically, right arithmetically, or rotate it right. The shift distance comes either from a small immediate field or from the bottom byte of a second register operand. Together with the shifted value, the unit produces new negative, zero and carry flags. The overflow flag passes through unchanged.

Register-sourced distances can be anywhere from 0 to 255. The carry output therefore has defined behaviour for distances of zero, exactly the word width, and larger than the word width. Decode, the register file and flag storage all sit outside this block. All outputs are purely combinational functions of the current inputs.

Top module: `shift_flag_unit`

## Requirements
- R1: `op_i` selects the operation. 2'b00 is logical left, 2'b01 is logical right, 2'b10 is arithmetic right and 2'b11 is rotate right. For distances 1 to 31 the result is the operand shifted or rotated by that distance.
- R2: When `use_reg_i` is 1, the distance is `rs_i[7:0]` and bits 31:8 of `rs_i` have no effect. When `use_reg_i` is 0, the distance is `imm_i`, zero-extended and taken as given for every operation.
- R3: `n_o` equals bit 31 of the result. `z_o` is 1 exactly when the whole result is zero.
- R4: `v_o` always equals `v_i`.
- R5: For a distance of 0, the result equals the operand and `c_o` equals `c_i`, for every operation. N and Z follow the result, so a left shift by immediate 0 acts as a move.
- R6: A logical left shift by exactly 32 gives result 0 with `c_o` equal to operand bit 0. A logical right shift by exactly 32 gives result 0 with `c_o` equal to operand bit 31.
- R7: Logical shifts by 33 to 255 give result 0 and `c_o` equal to 0.
- R8: An arithmetic right shift by 32 or more fills the result with operand bit 31, and `c_o` equals operand bit 31.
- R9: Rotate right uses the distance modulo 32. A nonzero multiple of 32 leaves the result unchanged, and then `c_o` equals operand bit 31. For any nonzero distance, `c_o` equals result bit 31.
- R10: For shift distances 1 to 31, `c_o` is the last bit moved out of the operand: bit 32-d for a left shift, and bit d-1 for the two right shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation select (see R1) |
| use_reg_i | input | 1 | 1: distance from register byte, 0: from immediate |
| operand_i | input | 32 | Value to be shifted |
| rs_i | input | 32 | Register holding the distance in its low byte |
| imm_i | input | 6 | Immediate distance |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| result_o | output | 32 | Shifted or rotated value |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| v_o | output | 1 | Overflow flag, passed through |

## Verification
All results are due in the same cycle as the stimulus, because there are no registers between the inputs and `result_o` or the flags. The bench applies each input set just after a rising clock edge and samples every output at the following falling edge. By then the combinational paths have settled, and no check races the edge where the next stimulus is applied. Expected values come from a reference model that moves bits out one step at a time and records the carry at each step. All four operations are swept across every distance from 0 to 255.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int AMT_W_DEF  = 8;
    localparam int IMM_W_DEF  = 6;

    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_LSR = 2'b01,
        OP_ASR = 2'b10,
        OP_ROR = 2'b11
    } shop_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int DATA_W = shift_pkg::DATA_W_DEF,
    parameter int AMT_W  = shift_pkg::AMT_W_DEF,
    parameter int IMM_W  = shift_pkg::IMM_W_DEF
) (
    input  logic              use_reg_i,
    input  logic [DATA_W-1:0] rs_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [AMT_W-1:0]  amt_o
);
    // only the low byte of the register takes part in the distance
    always_comb begin
        if (use_reg_i) amt_o = rs_i[AMT_W-1:0];
        else           amt_o = AMT_W'(imm_i);
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int AMT_W  = AMT_W_DEF
) (
    input  shop_e             op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam int SW = $clog2(DATA_W);

    logic [AMT_W-1:0]    amt_m1;
    logic [DATA_W-1:0]   lsl_v, lsl_pre, lsr_v, lsr_pre, asr_v, asr_pre, ror_v;
    logic [2*DATA_W-1:0] dbl;
    logic [SW-1:0]       rot_amt;

    // shifting by one step less exposes the last departing bit at the edge
    always_comb begin
        amt_m1  = amt_i - 1'b1;
        lsl_v   = a_i << amt_i;
        lsl_pre = a_i << amt_m1;
        lsr_v   = a_i >> amt_i;
        lsr_pre = a_i >> amt_m1;
        asr_v   = $signed(a_i) >>> amt_i;
        asr_pre = $signed(a_i) >>> amt_m1;
        rot_amt = amt_i[SW-1:0];
        dbl     = {a_i, a_i} >> rot_amt;
        ror_v   = dbl[DATA_W-1:0];
    end

    always_comb begin
        if (amt_i == '0) begin
            res_o = a_i;
            c_o   = c_i;
        end else begin
            unique case (op_i)
                OP_LSL: begin res_o = lsl_v; c_o = lsl_pre[DATA_W-1]; end
                OP_LSR: begin res_o = lsr_v; c_o = lsr_pre[0];        end
                OP_ASR: begin res_o = asr_v; c_o = asr_pre[0];        end
                default: begin res_o = ror_v; c_o = ror_v[DATA_W-1];   end
            endcase
        end
    end

    always_comb begin
        if (amt_i == '0) begin
            p_zero_keep_r5: assert (res_o == a_i && c_o == c_i)
                else $error("zero-distance shift altered value or carry");
        end
        if ((op_i == OP_LSL || op_i == OP_LSR) && amt_i > AMT_W'(DATA_W)) begin
            p_big_logical_r7: assert (res_o == '0 && !c_o)
                else $error("oversized logical shift not cleared");
        end
        if (op_i == OP_ASR && amt_i >= AMT_W'(DATA_W)) begin
            p_sign_fill_r8: assert (res_o == {DATA_W{a_i[DATA_W-1]}} && c_o == a_i[DATA_W-1])
                else $error("oversized arithmetic shift not sign filled");
        end
        if (op_i == OP_ROR && amt_i != '0) begin
            p_ror_carry_r9: assert (c_o == res_o[DATA_W-1])
                else $error("rotate carry differs from result msb");
        end
    end
endmodule

// File: rtl/shift_flags.sv
module shift_flags
    import shift_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              c_new_i,
    input  flags_t            old_i,
    output flags_t            new_o
);
    always_comb begin
        new_o.n = res_i[DATA_W-1];
        new_o.z = (res_i == '0);
        new_o.c = c_new_i;
        new_o.v = old_i.v;
    end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int AMT_W  = AMT_W_DEF,
    parameter int IMM_W  = IMM_W_DEF
) (
    input  logic [1:0]        op_i,
    input  logic              use_reg_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] rs_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    input  logic              v_i,
    output logic [DATA_W-1:0] result_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o
);
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] res;
    logic              c_new;
    flags_t            old_f, new_f;

    assign old_f = '{n: n_i, z: z_i, c: c_i, v: v_i};

    shift_amt_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amt (
        .use_reg_i(use_reg_i), .rs_i(rs_i), .imm_i(imm_i), .amt_o(amt)
    );

    shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .op_i(shop_e'(op_i)), .a_i(operand_i), .amt_i(amt), .c_i(c_i),
        .res_o(res), .c_o(c_new)
    );

    shift_flags #(.DATA_W(DATA_W)) u_flags (
        .res_i(res), .c_new_i(c_new), .old_i(old_f), .new_o(new_f)
    );

    assign result_o = res;
    assign n_o      = new_f.n;
    assign z_o      = new_f.z;
    assign c_o      = new_f.c;
    assign v_o      = new_f.v;

    always_comb begin
        p_v_pass_r4: assert (v_o == v_i) else $error("overflow flag changed");
        p_nz_track_r3: assert (n_o == result_o[DATA_W-1] && z_o == (result_o == '0))
            else $error("N/Z do not follow result");
    end
endmodule

// File: tb/shift_flag_unit_tb.sv
module shift_flag_unit_tb;
    logic        clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic [1:0]  op;
    logic        use_reg;
    logic [31:0] operand, rs;
    logic [5:0]  imm;
    logic        n_i, z_i, c_i, v_i;
    logic [31:0] result;
    logic        n_o, z_o, c_o, v_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    shift_flag_unit u_dut (
        .op_i(op), .use_reg_i(use_reg), .operand_i(operand), .rs_i(rs), .imm_i(imm),
        .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i),
        .result_o(result), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
    );

    // step-by-step reference: move one bit per step, keep the departing bit
    function automatic logic [32:0] ref_shift(input logic [1:0] o, input logic [31:0] a,
                                               input int d, input logic cin);
        logic [31:0] x = a;
        logic        c = cin;
        for (int i = 0; i < d; i++) begin
            case (o)
                2'b00: begin c = x[31]; x = {x[30:0], 1'b0}; end
                2'b01: begin c = x[0];  x = {1'b0, x[31:1]}; end
                2'b10: begin c = x[0];  x = {x[31], x[31:1]}; end
                default: begin c = x[0]; x = {x[0], x[31:1]}; end
            endcase
        end
        return {c, x};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (op=%0d reg=%0d a=%h rs=%h imm=%0d)",
                     tag, act, exp, op, use_reg, operand, rs, imm);
        end
    endtask

    // drive after a rising edge, sample at the next falling edge
    task automatic apply(input logic [1:0] o, input logic ur, input logic [31:0] a,
                         input logic [31:0] r, input logic [5:0] im, input logic [3:0] f);
        @(posedge clk);
        op = o; use_reg = ur; operand = a; rs = r; imm = im;
        {n_i, z_i, c_i, v_i} = f;
        @(negedge clk);
    endtask

    task automatic full_check(input string tag);
        logic [32:0] e;
        int d;
        d = use_reg ? int'(rs[7:0]) : int'(imm);
        e = ref_shift(op, operand, d, c_i);
        check({tag, " result"}, result, e[31:0]);
        check({tag, " C"}, {31'b0, c_o}, {31'b0, e[32]});
        check("R3 N", {31'b0, n_o}, {31'b0, e[31]});
        check("R3 Z", {31'b0, z_o}, {31'b0, e[31:0] == 32'h0});
        check("R4 V", {31'b0, v_o}, {31'b0, v_i});
    endtask

    task automatic t_idle();
        apply(2'b00, 1'b0, 32'h0, 32'h0, 6'd0, 4'b0000);
        check("R5 idle result", result, 32'h0);
        check("R3 idle Z", {31'b0, z_o}, 32'h1);
        check("R5 idle C", {31'b0, c_o}, 32'h0);
    endtask

    task automatic t_small();
        for (int o = 0; o < 4; o++)
            for (int d = 1; d < 32; d++) begin
                apply(o[1:0], 1'b1, 32'hB6D3_19E5, 32'(d), 6'd0, 4'b0101);
                full_check("R1 R10 small");
            end
    endtask

    task automatic t_source();
        apply(2'b01, 1'b1, 32'h8000_0F00, 32'hFFFF_FF04, 6'd20, 4'b0000);
        check("R2 reg byte", result, 32'h0800_00F0);
        apply(2'b01, 1'b0, 32'h8000_0F00, 32'hFFFF_FF04, 6'd8, 4'b0000);
        check("R2 imm", result, 32'h0080_000F);
        apply(2'b11, 1'b0, 32'h0000_0001, 32'h0, 6'd1, 4'b0000);
        check("R2 imm rotate", result, 32'h8000_0000);
    endtask

    task automatic t_zero();
        for (int o = 0; o < 4; o++) begin
            apply(o[1:0], 1'b1, 32'h8765_4321, 32'hABCD_EF00, 6'd9, 4'b0010);
            check("R5 zero result", result, 32'h8765_4321);
            check("R5 zero C kept", {31'b0, c_o}, 32'h1);
            check("R5 zero N", {31'b0, n_o}, 32'h1);
        end
        apply(2'b00, 1'b0, 32'h0, 32'h0, 6'd0, 4'b1010);
        check("R5 move Z", {31'b0, z_o}, 32'h1);
        check("R5 move C", {31'b0, c_o}, 32'h1);
    endtask

    task automatic t_word();
        apply(2'b00, 1'b0, 32'h0000_0001, 32'h0, 6'd32, 4'b0000);
        check("R6 lsl32 result", result, 32'h0);
        check("R6 lsl32 C", {31'b0, c_o}, 32'h1);
        apply(2'b01, 1'b1, 32'h8000_0000, 32'd32, 6'd0, 4'b0000);
        check("R6 lsr32 result", result, 32'h0);
        check("R6 lsr32 C", {31'b0, c_o}, 32'h1);
    endtask

    task automatic t_big();
        for (int d = 33; d < 256; d += 37) begin
            apply(2'b00, 1'b1, 32'hFFFF_FFFF, 32'(d), 6'd0, 4'b0010);
            check("R7 lsl big", result, 32'h0);
            check("R7 lsl big C", {31'b0, c_o}, 32'h0);
            apply(2'b01, 1'b1, 32'hFFFF_FFFF, 32'(d), 6'd0, 4'b0010);
            check("R7 lsr big", result, 32'h0);
            check("R7 lsr big C", {31'b0, c_o}, 32'h0);
        end
    endtask

    task automatic t_asr();
        apply(2'b10, 1'b1, 32'h8000_0000, 32'd32, 6'd0, 4'b0000);
        check("R8 asr32", result, 32'hFFFF_FFFF);
        check("R8 asr32 C", {31'b0, c_o}, 32'h1);
        apply(2'b10, 1'b1, 32'h7FFF_FFFF, 32'd200, 6'd0, 4'b0010);
        check("R8 asr200", result, 32'h0);
        check("R8 asr200 C", {31'b0, c_o}, 32'h0);
    endtask

    task automatic t_ror();
        apply(2'b11, 1'b1, 32'h8000_0001, 32'd64, 6'd0, 4'b0000);
        check("R9 ror64", result, 32'h8000_0001);
        check("R9 ror64 C", {31'b0, c_o}, 32'h1);
        apply(2'b11, 1'b1, 32'h0000_0010, 32'd36, 6'd0, 4'b0010);
        check("R9 ror36", result, 32'h0000_0001);
        check("R9 ror36 C", {31'b0, c_o}, 32'h0);
    endtask

    task automatic t_sweep();
        logic [31:0] vals [4] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h0};
        for (int k = 0; k < 4; k++) begin
            if (k == 3) vals[3] = $urandom;
            for (int o = 0; o < 4; o++)
                for (int d = 0; d < 256; d++) begin
                    apply(o[1:0], 1'b1, vals[k], {$urandom, 8'(d)} , 6'd0,
                          {2'b00, d[0], d[1]});
                    full_check("R6 R7 R8 R9 sweep");
                end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_small();
        t_source();
        t_zero();
        t_word();
        t_big();
        t_asr();
        t_ror();
        t_sweep();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule